// File: doc/BRIEF.md
# Software-Gated Stream Packet Release

This block sits on the path from a receive packet buffer to a stream-to-memory DMA engine. The DMA engine may keep its ready signal high even when no transfer is programmed. The block therefore watches the buffer's store side, counts the bytes of each packet from the byte-enable bits and keeps every finished length in a small in-order queue. It raises an interrupt when a packet completes. It keeps the egress valid signal low until software grants release, so that no data leaves before software has read the length.

Software reads the number of waiting packets and the length of the oldest one, programs a DMA transfer of exactly that size, and then writes the release command. One write releases one packet. The grant is used up on the handshaked last beat of that packet, and its queue entry is removed at the same moment. The packet data itself stays in the external buffer; the block gates the buffer's read side.

Top module: `pkt_release_gate`

## Requirements
- R1: The recorded length of a packet equals the sum of the set `st_tkeep` bits over all its handshaked store beats. The oldest waiting packet's length reads back at register word 1. That word reads 0 when nothing is waiting.
- R2: The pending count, read in bits [CNT_W-1:0] of register word 0, rises by one on each handshaked store beat with `st_tlast`. It falls by one on each handshaked egress beat with `dma_tlast`. It never exceeds DEPTH.
- R3: Without a release grant, `dma_tvalid` and `buf_tready` stay low while `dma_tready` is high and the buffer offers data.
- R4: Writing bit 0 of register word 2 grants the release of exactly one packet. Bit 16 of word 0 shows that a grant is outstanding. The grant ends on the handshaked last beat. A further release write made while a grant is outstanding is ignored. Beats leave unchanged and in stored order.
- R5: A release write made while the pending count is zero is ignored. A packet that arrives later stays held.
- R6: `st_tready` is low while DEPTH lengths are queued.
- R7: The interrupt status (bit 1 of word 3) is sticky and is set by every completed store packet. `irq` equals status AND enable (bit 0 of word 3, written through bit 0).
- R8: Writing 1 to bit 1 of word 3 clears the status. If packets are still pending after that write, the status is set again at once.
- R9: Writing bit 1 of word 2 clears the pending count, the length queue, the grant, the interrupt status and any partly counted packet. The interrupt enable is kept.
- R10: After `rst`, the pending count, head length, grant, interrupt status and `irq` are 0, `st_tready` is 1 and `dma_tvalid` is 0.
- R11: Lengths are removed in arrival order. After each release, the head length shows the next older packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_tvalid | input | 1 | Store-side beat valid |
| st_tready | output | 1 | Store-side ready, low while the length queue is full |
| st_tkeep | input | KEEP_W | Store-side byte enables |
| st_tlast | input | 1 | Store-side last beat of packet |
| buf_tvalid | input | 1 | Buffer read-side valid |
| buf_tready | output | 1 | Buffer read-side ready |
| buf_tdata | input | DATA_W | Buffer read-side data |
| buf_tkeep | input | KEEP_W | Buffer read-side byte enables |
| buf_tlast | input | 1 | Buffer read-side last beat |
| dma_tvalid | output | 1 | Egress valid toward the DMA engine |
| dma_tready | input | 1 | Egress ready from the DMA engine |
| dma_tdata | output | DATA_W | Egress data |
| dma_tkeep | output | KEEP_W | Egress byte enables |
| dma_tlast | output | 1 | Egress last beat |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following. Egress valid never rises while no packet is pending. Store ready is low at a full queue. The pending count stays within DEPTH and moves by at most one per cycle. Egress goes quiet in the cycle after a released last beat. An enabled interrupt follows each completed store packet. Other behaviour needs the bench's scenarios to show it: the exact byte length for each mix of beat count and final byte enables, the order of head lengths, ignored release writes, the reassertion after a clear, and the effect of a soft reset on a half-counted packet.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    WORD_STATUS = 2'd0,
    WORD_HEAD   = 2'd1,
    WORD_CTRL   = 2'd2,
    WORD_IRQ    = 2'd3
  } reg_word_e;

  localparam int BIT_RELEASE   = 0;
  localparam int BIT_SOFT_CLR  = 1;
  localparam int BIT_IRQ_EN    = 0;
  localparam int BIT_IRQ_STAT  = 1;
  localparam int BIT_GRANT     = 16;
endpackage

// File: rtl/prg_len_accum.sv
module prg_len_accum #(
  parameter int KEEP_W = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              beat,
  input  logic              last,
  input  logic [KEEP_W-1:0] keep,
  output logic [LEN_W-1:0]  len_total
);
  logic [LEN_W-1:0] acc_q;
  logic [LEN_W-1:0] beat_bytes;

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < KEEP_W; i++) begin
      beat_bytes = beat_bytes + LEN_W'(keep[i]);
    end
  end

  assign len_total = acc_q + beat_bytes;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (beat) begin
      acc_q <= last ? '0 : len_total;
    end
  end
endmodule

// File: rtl/prg_len_fifo.sv
module prg_len_fifo #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [LEN_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wp_q] <= push_len;
    end
  end

  assign head_len = empty ? '0 : mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_inc(wp_q);
      if (do_pop)  rp_q <= ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/prg_ctrl_regs.sv
module prg_ctrl_regs
  import prg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [LEN_W-1:0]  head_len,
  input  logic              arrive,
  input  logic              depart,
  output logic              soft_clr,
  output logic              grant,
  output logic              irq_en,
  output logic              irq,
  output logic [REG_DW-1:0] reg_rdata
);
  logic             rel_wr, clr_wr, en_wr;
  logic             grant_q, en_q, stat_q;
  logic [CNT_W-1:0] cnt_after;
  logic [REG_DW-1:0] rd_d;

  assign soft_clr = reg_wr && (reg_addr == WORD_CTRL) && reg_wdata[BIT_SOFT_CLR];
  assign rel_wr   = reg_wr && (reg_addr == WORD_CTRL) && reg_wdata[BIT_RELEASE];
  assign en_wr    = reg_wr && (reg_addr == WORD_IRQ);
  assign clr_wr   = en_wr && reg_wdata[BIT_IRQ_STAT];
  assign cnt_after = count + CNT_W'(arrive) - CNT_W'(depart);

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      grant_q <= 1'b0;
    end else if (depart) begin
      grant_q <= 1'b0;
    end else if (rel_wr && !grant_q && (count != '0)) begin
      grant_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (en_wr) begin
      en_q <= reg_wdata[BIT_IRQ_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      stat_q <= 1'b0;
    end else if (clr_wr) begin
      stat_q <= arrive || (cnt_after != '0);
    end else if (arrive) begin
      stat_q <= 1'b1;
    end
  end

  always_comb begin
    rd_d = '0;
    case (reg_word_e'(reg_addr))
      WORD_STATUS: begin
        rd_d[CNT_W-1:0]  = count;
        rd_d[BIT_GRANT]  = grant_q;
      end
      WORD_HEAD:   rd_d[LEN_W-1:0] = head_len;
      WORD_IRQ: begin
        rd_d[BIT_IRQ_EN]   = en_q;
        rd_d[BIT_IRQ_STAT] = stat_q;
      end
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_d;
    end
  end

  assign grant  = grant_q;
  assign irq_en = en_q;
  assign irq    = stat_q && en_q;
endmodule

// File: rtl/pkt_release_gate.sv
module pkt_release_gate
  import prg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 8,
  localparam int KEEP_W = DATA_W / 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_tvalid,
  output logic              st_tready,
  input  logic [KEEP_W-1:0] st_tkeep,
  input  logic              st_tlast,
  input  logic              buf_tvalid,
  output logic              buf_tready,
  input  logic [DATA_W-1:0] buf_tdata,
  input  logic [KEEP_W-1:0] buf_tkeep,
  input  logic              buf_tlast,
  output logic              dma_tvalid,
  input  logic              dma_tready,
  output logic [DATA_W-1:0] dma_tdata,
  output logic [KEEP_W-1:0] dma_tkeep,
  output logic              dma_tlast,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  logic             q_full, q_empty;
  logic [CNT_W-1:0] pend_cnt;
  logic [LEN_W-1:0] head_len, pkt_len;
  logic             store_hs, arrive, depart;
  logic             soft_clr, grant, irq_en;

  assign st_tready  = !q_full;
  assign store_hs   = st_tvalid && st_tready;
  assign arrive     = store_hs && st_tlast;

  assign dma_tvalid = buf_tvalid && grant;
  assign buf_tready = dma_tready && grant;
  assign dma_tdata  = buf_tdata;
  assign dma_tkeep  = buf_tkeep;
  assign dma_tlast  = buf_tlast;
  assign depart     = dma_tvalid && dma_tready && buf_tlast;

  prg_len_accum #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) accum_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_clr),
    .beat      (store_hs),
    .last      (st_tlast),
    .keep      (st_tkeep),
    .len_total (pkt_len)
  );

  prg_len_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) lenq_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_clr),
    .push     (arrive),
    .push_len (pkt_len),
    .pop      (depart),
    .head_len (head_len),
    .count    (pend_cnt),
    .full     (q_full),
    .empty    (q_empty)
  );

  prg_ctrl_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .count     (pend_cnt),
    .head_len  (head_len),
    .arrive    (arrive),
    .depart    (depart),
    .soft_clr  (soft_clr),
    .grant     (grant),
    .irq_en    (irq_en),
    .irq       (irq),
    .reg_rdata (reg_rdata)
  );

  logic unused_empty;
  assign unused_empty = q_empty;
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             st_tvalid,
  input logic             st_tready,
  input logic             st_tlast,
  input logic             dma_tvalid,
  input logic             dma_tready,
  input logic             dma_tlast,
  input logic [CNT_W-1:0] count,
  input logic             soft_clr,
  input logic             irq_en,
  input logic             irq
);
  assert_hold_without_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !dma_tvalid);

  assert_ready_low_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !st_tready);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                   count + 1'b1 == $past(count)));

  assert_one_packet_per_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (dma_tvalid && dma_tready && dma_tlast) |=> !dma_tvalid);

  assert_irq_on_arrival_R7: assert property (@(posedge clk) disable iff (rst)
    (st_tvalid && st_tready && st_tlast && !soft_clr) |=> (irq || !irq_en));
endmodule

bind pkt_release_gate prg_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .st_tvalid  (st_tvalid),
  .st_tready  (st_tready),
  .st_tlast   (st_tlast),
  .dma_tvalid (dma_tvalid),
  .dma_tready (dma_tready),
  .dma_tlast  (dma_tlast),
  .count      (pend_cnt),
  .soft_clr   (soft_clr),
  .irq_en     (irq_en),
  .irq        (irq)
);

// File: tb/pkt_release_gate_tb.sv
module pkt_release_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int KEEP_W = 4;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_tvalid = 1'b0, st_tlast = 1'b0;
  logic [KEEP_W-1:0] st_tkeep = '0;
  logic st_tready;
  logic buf_tvalid, buf_tready, buf_tlast;
  logic [DATA_W-1:0] buf_tdata;
  logic [KEEP_W-1:0] buf_tkeep;
  logic dma_tvalid, dma_tlast;
  logic dma_tready = 1'b1;
  logic [DATA_W-1:0] dma_tdata;
  logic [KEEP_W-1:0] dma_tkeep;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the external packet buffer
  logic [DATA_W-1:0] bm_data [256];
  logic [KEEP_W-1:0] bm_keep [256];
  logic              bm_last [256];
  logic [7:0] wr_p = '0, rd_p = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic [DATA_W-1:0] seq = '0;
  logic [DATA_W-1:0] exp_seq = '0;
  logic flush = 1'b0;
  int out_beats = 0, out_pkts = 0, data_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_release_gate #(.DATA_W(DATA_W), .LEN_W(16), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .st_tvalid(st_tvalid), .st_tready(st_tready), .st_tkeep(st_tkeep), .st_tlast(st_tlast),
    .buf_tvalid(buf_tvalid), .buf_tready(buf_tready), .buf_tdata(buf_tdata),
    .buf_tkeep(buf_tkeep), .buf_tlast(buf_tlast),
    .dma_tvalid(dma_tvalid), .dma_tready(dma_tready), .dma_tdata(dma_tdata),
    .dma_tkeep(dma_tkeep), .dma_tlast(dma_tlast),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  assign buf_tvalid = (rd_p != wr_p);
  assign buf_tdata  = bm_data[rd_p];
  assign buf_tkeep  = bm_keep[rd_p];
  assign buf_tlast  = bm_last[rd_p];

  always @(posedge clk) begin
    if (st_tvalid && st_tready) begin
      bm_data[wr_p] <= st_data;
      bm_keep[wr_p] <= st_tkeep;
      bm_last[wr_p] <= st_tlast;
      wr_p <= wr_p + 1'b1;
    end
    if (flush) begin
      rd_p    <= wr_p;
      exp_seq <= seq;
    end else if (buf_tvalid && buf_tready) begin
      rd_p <= rd_p + 1'b1;
    end
    if (dma_tvalid && dma_tready) begin
      out_beats <= out_beats + 1;
      if (dma_tdata != exp_seq) data_err <= data_err + 1;
      if (!flush) exp_seq <= exp_seq + 1'b1;
      if (dma_tlast) out_pkts <= out_pkts + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic store_beats(input int nb, input logic [3:0] lastkeep, input bit with_last);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      st_tvalid = 1'b1;
      st_tlast  = with_last && (b == nb - 1);
      st_tkeep  = (b == nb - 1) ? lastkeep : 4'hF;
      st_data   = seq;
      while (!st_tready) @(negedge clk);
      @(posedge clk);
      seq = seq + 1;
    end
    @(negedge clk);
    st_tvalid = 1'b0; st_tlast = 1'b0; st_tkeep = '0;
  endtask

  task automatic release_and_wait(input int nb);
    reg_write(2'd2, 32'h1);
    repeat (nb + 4) @(negedge clk);
  endtask

  function automatic int exp_len(input int nb, input logic [3:0] lastkeep);
    return 4 * (nb - 1) + $countones(lastkeep);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int base_pkts, base_beats;
    logic [3:0] kv [4];
    kv[0] = 4'h1; kv[1] = 4'h3; kv[2] = 4'h7; kv[3] = 4'hF;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check_eq("R10 st_tready", int'(st_tready), 1);
    check_eq("R10 dma_tvalid", int'(dma_tvalid), 0);
    check_eq("R10 irq", int'(irq), 0);
    reg_read(2'd0, rd); check_eq("R10 status word", int'(rd), 0);
    reg_read(2'd1, rd); check_eq("R10 head word", int'(rd), 0);
    reg_read(2'd3, rd); check_eq("R10 irq word", int'(rd), 0);

    // R5: release with nothing pending is ignored
    reg_write(2'd2, 32'h1);
    reg_read(2'd0, rd); check_eq("R5 grant after empty release", int'(rd[16]), 0);

    reg_write(2'd3, 32'h1);
    store_beats(3, 4'h3, 1);
    reg_read(2'd0, rd); check_eq("R2 count after one packet", int'(rd[3:0]), 1);
    reg_read(2'd1, rd); check_eq("R1 head length 3 beats", int'(rd), 10);
    check_eq("R7 irq after arrival", int'(irq), 1);
    // R3: greedy consumer gets nothing before a grant
    repeat (20) @(negedge clk);
    check_eq("R3 no beats before grant", out_beats, 0);
    check_eq("R3 buf_tready held low", int'(buf_tready), 0);
    check_eq("R5 late packet held", int'(dma_tvalid), 0);

    // R8: clear with a packet pending re-asserts status
    reg_write(2'd3, 32'h3);
    reg_read(2'd3, rd); check_eq("R8 status reasserts", int'(rd[1]), 1);

    release_and_wait(3);
    check_eq("R4 beats of released packet", out_beats, 3);
    check_eq("R4 packets released", out_pkts, 1);
    reg_read(2'd0, rd); check_eq("R2 count after drain", int'(rd[3:0]), 0);
    check_eq("R4 grant consumed", int'(rd[16]), 0);
    reg_write(2'd3, 32'h3);
    reg_read(2'd3, rd); check_eq("R8 status stays clear", int'(rd[1]), 0);
    check_eq("R8 irq low", int'(irq), 0);

    // R7: disabled interrupt still records status
    reg_write(2'd3, 32'h0);
    store_beats(1, 4'hF, 1);
    check_eq("R7 irq masked", int'(irq), 0);
    reg_read(2'd3, rd); check_eq("R7 status sticky", int'(rd[1]), 1);
    reg_write(2'd3, 32'h1);
    @(negedge clk); check_eq("R7 irq after enable", int'(irq), 1);
    release_and_wait(1);

    // R4: double release lets one packet through
    store_beats(2, 4'hF, 1);
    store_beats(2, 4'h1, 1);
    base_pkts = out_pkts;
    reg_write(2'd2, 32'h1);
    reg_write(2'd2, 32'h1);
    repeat (8) @(negedge clk);
    check_eq("R4 second write ignored", out_pkts - base_pkts, 1);
    reg_read(2'd1, rd); check_eq("R11 next head length", int'(rd), 5);
    release_and_wait(2);
    reg_read(2'd0, rd); check_eq("R2 count zero again", int'(rd[3:0]), 0);

    // R1 sweep over beat counts and final byte enables
    for (int nb = 1; nb <= 5; nb++) begin
      for (int k = 0; k < 4; k++) begin
        base_beats = out_beats;
        store_beats(nb, kv[k], 1);
        reg_read(2'd1, rd);
        check_eq($sformatf("R1 length nb=%0d keep=%0h", nb, kv[k]), int'(rd), exp_len(nb, kv[k]));
        release_and_wait(nb);
        check_eq("R4 beat count per release", out_beats - base_beats, nb);
      end
    end

    // R6 / R11: fill the queue, then drain in order
    for (int i = 0; i < DEPTH; i++) store_beats(1, kv[i % 4], 1);
    check_eq("R6 ready low when full", int'(st_tready), 0);
    reg_read(2'd0, rd); check_eq("R2 count full", int'(rd[3:0]), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      reg_read(2'd1, rd);
      check_eq($sformatf("R11 head order %0d", i), int'(rd), (i % 4) + 1);
      release_and_wait(1);
      check_eq("R6 ready back", int'(st_tready), 1);
    end
    reg_read(2'd0, rd); check_eq("R2 count drained", int'(rd[3:0]), 0);

    // R9 soft reset with pending packets and a partial one
    store_beats(2, 4'hF, 1);
    store_beats(1, 4'h3, 1);
    store_beats(2, 4'hF, 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h2; flush = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; flush = 1'b0;
    reg_read(2'd0, rd); check_eq("R9 count cleared", int'(rd), 0);
    reg_read(2'd1, rd); check_eq("R9 head cleared", int'(rd), 0);
    reg_read(2'd3, rd); check_eq("R9 status cleared enable kept", int'(rd), 1);
    check_eq("R9 irq low", int'(irq), 0);
    store_beats(1, 4'hF, 1);
    reg_read(2'd1, rd); check_eq("R9 partial length discarded", int'(rd), 4);
    release_and_wait(1);

    check_eq("R4 egress data order", data_err, 0);
    finish_run();
  end
endmodule